// File: doc/BRIEF.md
# Low-Power Sleep Depth Controller

This block sits beside a processor core and picks how deeply the chip powers down when the core executes its sleep instruction. Two selection bits, each taken from its own standby control register, choose the depth in priority order: standby, then deep sleep, then plain sleep. The block holds a four-state machine and turns the current state into per-peripheral clock-halt enables for the timer, the serial port and the DMA engine.

On standby entry the timer and serial port keep their clocks for a short catch-up window of `CATCHUP_CYC` cycles, marked by the `catchup` output, so they can bring their counts up to date before they stop. Deep sleep stops only the DMA engine. Plain sleep stops nothing. A pending interrupt or a reset request returns the controller to running, releases every halt, and raises `wake_pulse` for one cycle so the core can take the interrupt.

States and transitions: RUNNING (code 0) goes to STANDBY (code 3), DEEP_SLEEP (code 2) or SLEEP (code 1) on a sleep request. Each low-power state goes back to RUNNING on an interrupt or a reset request. No other transition exists.

Top module: `lpm_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `state_o` is 0 (RUNNING) and all halt enables, `catchup` and `wake_pulse` are 0.
- R2: A `sleep_req` sampled in RUNNING with `stby_sel`=1 and no `wake_rst` moves `state_o` to 3 (STANDBY) at the next edge, whatever `deep_sel` is.
- R3: A `sleep_req` sampled in RUNNING with `stby_sel`=0, `deep_sel`=1 and no `wake_rst` moves `state_o` to 2 (DEEP_SLEEP).
- R4: A `sleep_req` sampled in RUNNING with both selection bits 0 and no `wake_rst` moves `state_o` to 1 (SLEEP).
- R5: For the first `CATCHUP_CYC` cycles in STANDBY, `catchup` is 1 and `halt_tmr`/`halt_ser` are 0. From then on in STANDBY, `catchup` is 0 and `halt_tmr`/`halt_ser` are 1. `halt_dma` is 0 throughout STANDBY.
- R6: In DEEP_SLEEP, `halt_dma` is 1 from the first cycle and `halt_tmr`/`halt_ser` are 0. In SLEEP and RUNNING, all halt enables are 0.
- R7: In any low-power state, `irq_pend` or `wake_rst` sampled at an edge returns `state_o` to 0. In that first RUNNING cycle, every halt enable and `catchup` is 0.
- R8: `wake_pulse` is 1 in exactly the first RUNNING cycle after a low-power state, and 0 in every other cycle.
- R9: A `sleep_req` sampled in a low-power state has no effect: the state and the halt enables follow only the wakeup rule.
- R10: `wake_rst` sampled in RUNNING keeps the state at RUNNING even when `sleep_req` is 1, and raises no `wake_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Strobe from the core when a sleep instruction executes |
| stby_sel | input | 1 | Standby select bit from the first standby control register |
| deep_sel | input | 1 | Deep-sleep select bit from the second standby control register |
| irq_pend | input | 1 | An interrupt is pending |
| wake_rst | input | 1 | Synchronous reset request that forces RUNNING |
| state_o | output | 2 | Current state: 0 RUNNING, 1 SLEEP, 2 DEEP_SLEEP, 3 STANDBY |
| halt_tmr | output | 1 | Clock-halt enable for the timer |
| halt_ser | output | 1 | Clock-halt enable for the serial port |
| halt_dma | output | 1 | Clock-halt enable for the DMA engine |
| catchup | output | 1 | Standby catch-up window: timer and serial still clocked |
| wake_pulse | output | 1 | One-cycle strobe on return to RUNNING |

## Verification
The bench builds the block with `CATCHUP_CYC` set to 3 instead of the default 1. With that setting the catch-up window lasts several cycles, so wakeups can be placed inside the window, on its last cycle and after it. The bench sweeps every combination of the two selection bits, both wakeup causes and low-power dwell times from 1 to 6 cycles. It also sends ignored sleep requests on alternating cycles of each dwell, which puts every transition and every halt pattern against each dwell length.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        LPM_RUN   = 2'd0,
        LPM_SLEEP = 2'd1,
        LPM_DEEP  = 2'd2,
        LPM_STBY  = 2'd3
    } lpm_state_e;

    localparam int NUM_PER = 3;
    localparam int PER_TMR = 0;
    localparam int PER_SER = 1;
    localparam int PER_DMA = 2;

    // peripherals that keep running through the standby catch-up window
    localparam logic [NUM_PER-1:0] CATCHUP_MASK = 3'b011;

    function automatic logic [NUM_PER-1:0] halt_set(input lpm_state_e s);
        logic [NUM_PER-1:0] m;
        m = '0;
        case (s)
            LPM_STBY: begin
                m[PER_TMR] = 1'b1;
                m[PER_SER] = 1'b1;
            end
            LPM_DEEP:  m[PER_DMA] = 1'b1;
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lpm_depth_sel.sv
module lpm_depth_sel
    import lpm_pkg::*;
(
    input  logic       stby_sel,
    input  logic       deep_sel,
    output lpm_state_e target
);
    // standby outranks deep sleep, deep sleep outranks plain sleep
    always_comb begin
        if (stby_sel)
            target = LPM_STBY;
        else if (deep_sel)
            target = LPM_DEEP;
        else
            target = LPM_SLEEP;
    end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       irq_pend,
    input  logic       wake_rst,
    input  lpm_state_e target,
    output lpm_state_e state
);
    lpm_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= LPM_RUN;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            LPM_RUN: begin
                if (!wake_rst && sleep_req)
                    state_nxt = target;
            end
            LPM_SLEEP, LPM_DEEP, LPM_STBY: begin
                // further sleep requests are ignored here
                if (irq_pend || wake_rst)
                    state_nxt = LPM_RUN;
            end
        endcase
    end
endmodule

// File: rtl/lpm_out_gen.sv
module lpm_out_gen
    import lpm_pkg::*;
#(
    parameter int CATCHUP_CYC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lpm_state_e         state,
    output logic [NUM_PER-1:0] halt,
    output logic               catchup,
    output logic               wake_pulse
);
    localparam int CNT_W = $clog2(CATCHUP_CYC + 2);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(CATCHUP_CYC);

    logic [CNT_W-1:0]   stby_cnt;
    logic               was_run_q;
    logic [NUM_PER-1:0] base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stby_cnt  <= '0;
            was_run_q <= 1'b1;
        end else begin
            was_run_q <= (state == LPM_RUN);
            if (state != LPM_STBY)
                stby_cnt <= '0;
            else if (stby_cnt < CNT_LIM)
                stby_cnt <= stby_cnt + 1'b1;
        end
    end

    always_comb begin
        base       = halt_set(state);
        catchup    = (state == LPM_STBY) && (stby_cnt < CNT_LIM);
        wake_pulse = (state == LPM_RUN) && !was_run_q;
    end

    for (genvar g = 0; g < NUM_PER; g++) begin : g_halt
        if (CATCHUP_MASK[g]) begin : g_held
            assign halt[g] = base[g] & ~catchup;
        end else begin : g_direct
            assign halt[g] = base[g];
        end
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int CATCHUP_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       stby_sel,
    input  logic       deep_sel,
    input  logic       irq_pend,
    input  logic       wake_rst,
    output logic [1:0] state_o,
    output logic       halt_tmr,
    output logic       halt_ser,
    output logic       halt_dma,
    output logic       catchup,
    output logic       wake_pulse
);
    lpm_state_e         target;
    lpm_state_e         state;
    logic [NUM_PER-1:0] halt;

    lpm_depth_sel u_sel (
        .stby_sel (stby_sel),
        .deep_sel (deep_sel),
        .target   (target)
    );

    lpm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .irq_pend  (irq_pend),
        .wake_rst  (wake_rst),
        .target    (target),
        .state     (state)
    );

    lpm_out_gen #(.CATCHUP_CYC(CATCHUP_CYC)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .halt       (halt),
        .catchup    (catchup),
        .wake_pulse (wake_pulse)
    );

    assign state_o  = state;
    assign halt_tmr = halt[PER_TMR];
    assign halt_ser = halt[PER_SER];
    assign halt_dma = halt[PER_DMA];
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
    import lpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       stby_sel,
    input logic       deep_sel,
    input logic       irq_pend,
    input logic       wake_rst,
    input logic [1:0] state_o,
    input logic       halt_tmr,
    input logic       halt_ser,
    input logic       halt_dma,
    input logic       catchup,
    input logic       wake_pulse
);
    logic in_run;
    assign in_run = (state_o == LPM_RUN);

    AST_ENTER_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && sleep_req && !wake_rst && stby_sel) |=> (state_o == LPM_STBY)); // R2
    AST_ENTER_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && sleep_req && !wake_rst && !stby_sel && deep_sel) |=> (state_o == LPM_DEEP)); // R3
    AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && sleep_req && !wake_rst && !stby_sel && !deep_sel) |=> (state_o == LPM_SLEEP)); // R4
    AST_CATCHUP_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        catchup |-> (state_o == LPM_STBY && !halt_tmr && !halt_ser && !halt_dma)); // R5
    AST_STBY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == LPM_STBY && !catchup) |-> (halt_tmr && halt_ser && !halt_dma)); // R5
    AST_DEEP_DMA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == LPM_DEEP) |-> (halt_dma && !halt_tmr && !halt_ser)); // R6
    AST_LIGHT_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == LPM_SLEEP || in_run) |-> (!halt_dma && !halt_tmr && !halt_ser)); // R6
    AST_WAKE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_run && (irq_pend || wake_rst)) |=> (in_run && wake_pulse && !catchup)); // R7
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R8
    AST_WAKE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> in_run); // R8
    AST_SLEEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_run && !irq_pend && !wake_rst) |=> $stable(state_o)); // R9
    AST_RST_HOLDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && wake_rst) |=> (in_run && !wake_pulse)); // R10
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .stby_sel   (stby_sel),
    .deep_sel   (deep_sel),
    .irq_pend   (irq_pend),
    .wake_rst   (wake_rst),
    .state_o    (state_o),
    .halt_tmr   (halt_tmr),
    .halt_ser   (halt_ser),
    .halt_dma   (halt_dma),
    .catchup    (catchup),
    .wake_pulse (wake_pulse)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
    localparam int CATCH = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       stby_sel = 1'b0;
    logic       deep_sel = 1'b0;
    logic       irq_pend = 1'b0;
    logic       wake_rst = 1'b0;
    logic [1:0] state_o;
    logic       halt_tmr, halt_ser, halt_dma, catchup, wake_pulse;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lpm_ctrl #(.CATCHUP_CYC(CATCH)) u_lpm_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .stby_sel   (stby_sel),
        .deep_sel   (deep_sel),
        .irq_pend   (irq_pend),
        .wake_rst   (wake_rst),
        .state_o    (state_o),
        .halt_tmr   (halt_tmr),
        .halt_ser   (halt_ser),
        .halt_dma   (halt_dma),
        .catchup    (catchup),
        .wake_pulse (wake_pulse)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // outputs packed as {state, tmr, ser, dma, catchup, wake}
    function automatic int outs();
        return {state_o, halt_tmr, halt_ser, halt_dma, catchup, wake_pulse};
    endfunction

    function automatic int pack(int st, int t, int s, int d, int c, int w);
        return (st << 5) | (t << 4) | (s << 3) | (d << 2) | (c << 1) | w;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", outs(), pack(0, 0, 0, 0, 0, 0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", outs(), pack(0, 0, 0, 0, 0, 0));

        // R10: reset request in RUNNING beats a simultaneous sleep
        sleep_req = 1'b1; stby_sel = 1'b1; wake_rst = 1'b1;
        @(negedge clk);
        chk("R10", "run held, no pulse", outs(), pack(0, 0, 0, 0, 0, 0));
        sleep_req = 1'b0; wake_rst = 1'b0; stby_sel = 1'b0;
        @(negedge clk);
        chk("R10", "still running", outs(), pack(0, 0, 0, 0, 0, 0));

        // sweep: selection bits x wake cause x dwell length
        for (int sel = 0; sel < 4; sel++) begin
            for (int cause = 0; cause < 2; cause++) begin
                for (int hold = 1; hold <= 6; hold++) begin
                    int sb, db, exp_st;
                    string rq;
                    sb = sel[1];
                    db = sel[0];
                    exp_st = sb ? 3 : (db ? 2 : 1);
                    rq = sb ? "R2" : (db ? "R3" : "R4");
                    stby_sel = sb[0]; deep_sel = db[0]; sleep_req = 1'b1;
                    @(negedge clk);
                    sleep_req = 1'b0;
                    for (int i = 0; i < hold; i++) begin
                        int et, ed, ec;
                        ec = (sb != 0 && i < CATCH) ? 1 : 0;
                        et = (sb != 0 && i >= CATCH) ? 1 : 0;
                        ed = (sb == 0 && db != 0) ? 1 : 0;
                        if (i == 0)
                            chk(rq, "entered state", int'(state_o), exp_st);
                        else
                            chk("R9", "state after ignored sleep", int'(state_o), exp_st);
                        if (sb != 0)
                            chk("R5", "standby outputs", outs(), pack(exp_st, et, et, 0, ec, 0));
                        else
                            chk("R6", "sleep/deep outputs", outs(), pack(exp_st, 0, 0, ed, 0, 0));
                        // R9: alternate sleep requests with flipped selection
                        sleep_req = (i % 2 == 0);
                        stby_sel = ~stby_sel;
                        deep_sel = ~deep_sel;
                        if (i == hold - 1) begin
                            sleep_req = 1'b0;
                            if (cause == 0) irq_pend = 1'b1;
                            else            wake_rst = 1'b1;
                        end
                        @(negedge clk);
                    end
                    irq_pend = 1'b0; wake_rst = 1'b0;
                    chk("R7", "back to running", outs(), pack(0, 0, 0, 0, 0, 1));
                    @(negedge clk);
                    chk("R8", "pulse single cycle", outs(), pack(0, 0, 0, 0, 0, 0));
                end
            end
        end

        // R6: idle running with stray interrupts raises nothing
        irq_pend = 1'b1;
        @(negedge clk);
        chk("R6", "running with irq", outs(), pack(0, 0, 0, 0, 0, 0));
        irq_pend = 1'b0;
        @(negedge clk);
        chk("R8", "no pulse without sleep", int'(wake_pulse), 0);
        finish_run();
    end
endmodule